// File: doc/BRIEF.md
# Character Input Port with Ready Flag and Interrupt

This block links a device that produces 8-bit characters (such as a keyboard front end) to a processor. The device presents a character together with a one-cycle strobe. The processor sees the port as three word-aligned registers on a simple synchronous register bus. The registers are a character register, a status register and a control register. The processor reaches them with ordinary loads and stores.

When a character arrives, the port stores it and raises a ready flag. Software can poll the status register as often as it likes without disturbing anything except the sticky overrun indication. Reading the character register hands the character to the processor and drops the ready flag in the same access. When the interrupt-enable bit in the control register is set, the ready flag is also presented as a level interrupt request.

Top module: `char_input_port`

## Requirements
- R1: After reset, the character register, the ready flag, the overrun flag and the interrupt enable are all zero. Reads of offsets 0, 4 and 8 return 0 and `irq` is low.
- R2: Register offsets are fixed: character at 0, status at 4 and control at 8. Read data is registered: it appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`, and is 0 in any cycle that follows an edge without a read. A read of any other offset returns 0.
- R3: A cycle with `char_valid` high stores `char_in` in the character register and sets the ready flag, which is status bit 1.
- R4: A read of offset 0 returns the stored character and clears the ready flag in the same access.
- R5: A read of the status register returns {6'b0, ready, overrun} and changes neither the stored character nor the ready flag.
- R6: A character arriving in the same cycle as a read of offset 0 is stored, and the ready flag ends up set. The read returns the previous character, and no overrun is recorded.
- R7: A character arriving while the ready flag is set, with no read of offset 0 in that cycle, overwrites the character register and sets the sticky overrun flag (status bit 0).
- R8: A status read returns the overrun flag and then clears it. If a new overrun occurs in the same cycle, the flag stays set.
- R9: Control bit 1 is the interrupt enable. It is written from `bus_wdata[1]` and read back at bit 1, and all other control bits read as 0.
- R10: `irq` is high exactly when the ready flag and the interrupt enable are both set.
- R11: Writes to offsets 0 and 4 change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | One-cycle strobe: new character on `char_in` |
| char_in | input | 8 | Character from the device |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can collide. A character can arrive in the same cycle as a read of the character register, and an overrun can occur in the same cycle as a status read. The bench provokes each collision by raising the device strobe and the bus read strobe on the same falling edge, so that a single rising edge samples both. It judges the outcome from the value returned by that read and from the status and character values read back in the following accesses.

// File: rtl/char_port_pkg.sv
package char_port_pkg;
  localparam int unsigned CP_DW      = 8;
  localparam int unsigned OFS_CHAR   = 0;
  localparam int unsigned OFS_STAT   = 4;
  localparam int unsigned OFS_CTRL   = 8;
  localparam int unsigned BIT_READY  = 1;
  localparam int unsigned BIT_OVR    = 0;
  localparam int unsigned BIT_IE     = 1;
  localparam logic [CP_DW-1:0] CTRL_MASK = CP_DW'(1) << BIT_IE;

  typedef enum logic [1:0] {SEL_NONE, SEL_CHAR, SEL_STAT, SEL_CTRL} reg_sel_e;

  function automatic logic [CP_DW-1:0] status_word(input logic rdy, input logic ovr);
    logic [CP_DW-1:0] w;
    w = '0;
    w[BIT_READY] = rdy;
    w[BIT_OVR]   = ovr;
    return w;
  endfunction
endpackage

// File: rtl/cip_decode.sv
module cip_decode
  import char_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              char_rd_hit,
  output logic              stat_rd_hit,
  output logic              ctrl_wr_hit,
  output logic              char_wr_hit
);
  always_comb begin
    if (addr == ADDR_W'(OFS_CHAR))      sel = SEL_CHAR;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
    else                                sel = SEL_NONE;
  end

  assign char_rd_hit = rd && (sel == SEL_CHAR);
  assign stat_rd_hit = rd && (sel == SEL_STAT);
  assign ctrl_wr_hit = wr && (sel == SEL_CTRL);
  assign char_wr_hit = wr && (sel == SEL_CHAR);
endmodule

// File: rtl/cip_char_store.sv
module cip_char_store
  import char_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             char_valid,
  input  logic [CP_DW-1:0] char_in,
  input  logic             char_rd_hit,
  input  logic             stat_rd_hit,
  output logic [CP_DW-1:0] char_q,
  output logic             ready_q,
  output logic             ovr_q
);
  logic ev_arrive;
  logic ev_overrun;
  logic ev_consume;

  assign ev_arrive  = char_valid;
  assign ev_overrun = char_valid && ready_q && !char_rd_hit;
  assign ev_consume = char_rd_hit && !char_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (ev_arrive) char_q <= char_in;
      if (ev_arrive)       ready_q <= 1'b1;
      else if (ev_consume) ready_q <= 1'b0;
      if (ev_overrun)       ovr_q <= 1'b1;
      else if (stat_rd_hit) ovr_q <= 1'b0;
    end
  end

  a_r3_arrival_loads: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> (ready_q && char_q == $past(char_in)));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rd_hit && !char_valid) |=> !ready_q);
  a_r5_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_hit && !char_valid && !char_rd_hit) |=> ($stable(ready_q) && $stable(char_q)));
  a_r6_arrival_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_rd_hit && !ovr_q && !stat_rd_hit) |=> (ready_q && !ovr_q));
  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && ready_q && !char_rd_hit) |=> ovr_q);
  a_r8_poll_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_hit && !(char_valid && ready_q)) |=> !ovr_q);
endmodule

// File: rtl/cip_ctrl_reg.sv
module cip_ctrl_reg
  import char_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_hit,
  input  logic [CP_DW-1:0] wdata,
  input  logic             ready_q,
  output logic [CP_DW-1:0] ctrl_q,
  output logic             ie,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl_q <= '0;
    else if (ctrl_wr_hit) ctrl_q <= wdata & CTRL_MASK;
  end

  assign ie  = ctrl_q[BIT_IE];
  assign irq = ready_q & ie;

  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_hit |=> (ie == $past(wdata[BIT_IE])));
endmodule

// File: rtl/char_input_port.sv
module char_input_port
  import char_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [CP_DW-1:0]  char_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CP_DW-1:0]  bus_wdata,
  output logic [CP_DW-1:0]  bus_rdata,
  output logic              irq
);
  reg_sel_e         sel;
  logic             char_rd_hit, stat_rd_hit, ctrl_wr_hit, char_wr_hit;
  logic [CP_DW-1:0] char_q, ctrl_q, rd_mux;
  logic             ready_q, ovr_q, ie;

  cip_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel),
    .char_rd_hit(char_rd_hit), .stat_rd_hit(stat_rd_hit),
    .ctrl_wr_hit(ctrl_wr_hit), .char_wr_hit(char_wr_hit)
  );

  cip_char_store u_store (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
    .char_rd_hit(char_rd_hit), .stat_rd_hit(stat_rd_hit),
    .char_q(char_q), .ready_q(ready_q), .ovr_q(ovr_q)
  );

  cip_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_hit(ctrl_wr_hit), .wdata(bus_wdata),
    .ready_q(ready_q), .ctrl_q(ctrl_q), .ie(ie), .irq(irq)
  );

  always_comb begin
    unique case (sel)
      SEL_CHAR: rd_mux = char_q;
      SEL_STAT: rd_mux = status_word(ready_q, ovr_q);
      SEL_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end

  a_r10_irq_drops_on_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rd_hit && !char_valid) |=> !irq);
  a_r10_irq_follows_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && ie && !ctrl_wr_hit) |=> irq);
  a_r11_char_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (char_wr_hit && !char_valid) |=> $stable(char_q));
  a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_char_input_port.sv
module sim_char_input_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          char_valid = 1'b0;
  logic [7:0]    char_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_input_port #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); char_in = c; char_valid = 1'b1;
    @(negedge clk); char_valid = 1'b0;
  endtask

  task automatic rd_with_char(input logic [AW-1:0] a, input logic [7:0] c, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; char_in = c; char_valid = 1'b1;
    @(negedge clk); d = bus_rdata; bus_rd = 1'b0; char_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(4'd0, d); check("R1 char", d, 8'h00);
    rd(4'd4, d); check("R1 status", d, 8'h00);
    rd(4'd8, d); check("R1 control", d, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] d;
    wr(4'd8, 8'h02);
    rd(4'd12, d); check("R2 unmapped 12", d, 8'h00);
    rd(4'd2, d);  check("R2 unmapped 2", d, 8'h00);
    @(negedge clk); check("R2 idle rdata", bus_rdata, 8'h00);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_arrive_consume;
    logic [7:0] d;
    send(8'h41);
    rd(4'd4, d); check("R3 ready set", d, 8'h02);
    rd(4'd4, d); check("R5 poll keeps ready", d, 8'h02);
    rd(4'd0, d); check("R5 poll keeps char / R3 stored", d, 8'h41);
    rd(4'd4, d); check("R4 read clears ready", d, 8'h00);
    rd(4'd0, d); check("R4 char still held", d, 8'h41);
  endtask

  task automatic t_ctrl_irq;
    logic [7:0] d;
    wr(4'd8, 8'hFF);
    rd(4'd8, d); check("R9 only enable bit", d, 8'h02);
    check("R10 irq low without ready", {7'b0, irq}, 8'h00);
    send(8'h55);
    check("R10 irq high", {7'b0, irq}, 8'h01);
    wr(4'd8, 8'h00);
    check("R10 irq off when disabled", {7'b0, irq}, 8'h00);
    wr(4'd8, 8'h02);
    check("R10 irq back on", {7'b0, irq}, 8'h01);
    rd(4'd0, d); check("R4 char under irq", d, 8'h55);
    check("R10 irq drops on consume", {7'b0, irq}, 8'h00);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_ignored_writes;
    logic [7:0] d;
    send(8'h33);
    wr(4'd0, 8'h77);
    wr(4'd4, 8'hFF);
    rd(4'd4, d); check("R11 status unchanged", d, 8'h02);
    rd(4'd0, d); check("R11 char unchanged", d, 8'h33);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    send(8'h10);
    rd_with_char(4'd0, 8'h20, d); check("R6 returns old char", d, 8'h10);
    rd(4'd4, d); check("R6 ready set, no overrun", d, 8'h02);
    rd(4'd0, d); check("R6 new char kept", d, 8'h20);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    send(8'h01);
    send(8'h02);
    rd(4'd4, d); check("R7 overrun flagged", d, 8'h03);
    rd(4'd4, d); check("R8 overrun cleared", d, 8'h02);
    rd(4'd0, d); check("R7 char overwritten", d, 8'h02);
    send(8'h05);
    send(8'h06);
    rd_with_char(4'd4, 8'h07, d); check("R8 status with overrun", d, 8'h03);
    rd(4'd4, d); check("R8 new overrun wins clear", d, 8'h03);
    rd(4'd4, d); check("R8 then cleared", d, 8'h02);
    rd(4'd0, d); check("R7 latest char", d, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_arrive_consume;
    t_ctrl_irq;
    t_ignored_writes;
    t_same_cycle;
    t_overrun;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule